// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel serial audio stream into parallel 24-bit samples. It receives three lines: a word clock that marks the channel halves, a bit clock, and a serial data line. It treats all three as plain inputs and oversamples them with the system clock. The block does not run logic on the bit clock.

A static setting picks the framing. Left-justified framing takes the bits that start at the word-clock transition. Right-justified framing takes the bits that end at the next transition. I2S framing takes the data one bit-clock after the transition. A single shift engine handles all three framings and can place the first received bit at either end of the sample.

The block collects one left sample and one right sample. Once the right half-period has ended, it presents the pair together with a one-cycle strobe. The system clock must run several times faster than the bit clock, so that every bit-clock level lasts at least two system cycles.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_i` selects the framing: 0 is left-justified, 1 is right-justified, 2 is I2S, and 3 is illegal. `lsb_first_i` = 1 selects LSB-first order in the left-justified and right-justified framings. In I2S the data is always MSB-first and `lsb_first_i` has no effect.
- R2: The word clock, bit clock and data pass through the same two-flop synchronizer. Data is taken only on rising edges of the synchronized bit clock.
- R3: Left-justified: the first 24 bit-clock rises after a word-clock transition form the sample. Any later rises in the same half-period are ignored.
- R4: Right-justified: the last 24 bit-clock rises before the next word-clock transition form the sample. Any earlier rises in the half-period are ignored.
- R5: I2S: the first bit-clock rise after a word-clock transition is skipped. The next 24 rises carry bits 23 down to 0. Later rises are ignored. Word clock low is the left channel.
- R6: In the left-justified and right-justified framings, word clock high is the left channel (channel A) and low is the right channel (channel B).
- R7: When a right half-period ends (at the word-clock transition that follows it), `left_o`/`right_o` load the pair and `valid_o` is high for exactly one cycle. Between strobes the outputs hold their value.
- R8: After reset `left_o`, `right_o` and `valid_o` are 0. The half-period in progress at reset is discarded. A strobe is issued only after a complete left half followed by a complete right half.
- R9: LSB-first order puts the first accepted bit in sample bit 0. MSB-first order puts it in bit 23.
- R10: A half-period must contain at least 24 bit-clock cycles (25 in I2S). The per-half bit counter saturates at `MAX_SLOTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing select (static) |
| lsb_first_i | input | 1 | Bit order for left-justified and right-justified framings |
| wclk_i | input | 1 | Word clock, asynchronous |
| aclk_i | input | 1 | Bit clock, asynchronous |
| ain_i | input | 1 | Serial data, asynchronous |
| left_o | output | SAMPLE_W | Left (channel A) sample |
| right_o | output | SAMPLE_W | Right (channel B) sample |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The bench builds the block with its defaults: 24-bit samples, a 64-slot counter limit and two synchronizer stages. The bit clock runs at eight system cycles per period, so each level lasts four system cycles, which clears the two-flop delay. Half-periods of 24, 25, 32 and 40 slots keep the counter below saturation. These lengths reach three cases: the exact-fit case with no spare slots, the minimum I2S length, and long halves where junk bits must be rejected on either side of the data window.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_RJ  = 2'd1,
    FMT_I2S = 2'd2
  } sarx_fmt_e;
endpackage

// File: rtl/sarx_sync.sv
`timescale 1ns/1ps
module sarx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             primed_o
);
  localparam int FILL   = STAGES + 1;
  localparam int FILL_W = $clog2(FILL + 1);
  localparam logic [FILL_W-1:0] FILL_END = FILL_W'(FILL);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [FILL_W-1:0]            fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      fill_q  <= '0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], async_i};
      if (fill_q != FILL_END) fill_q <= fill_q + 1'b1;
    end
  end

  assign sync_o   = stage_q[STAGES-1];
  // edges are only trusted once the pipeline and the edge history hold real samples
  assign primed_o = (fill_q == FILL_END);

  AST_PRIMED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_o |=> primed_o); // R2
endmodule

// File: rtl/sarx_shift.sv
`timescale 1ns/1ps
module sarx_shift import sarx_pkg::*; #(
  parameter int SAMPLE_W  = 24,
  parameter int MAX_SLOTS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  sarx_fmt_e           fmt_i,
  input  logic                lsb_first_i,
  input  logic                primed_i,
  input  logic                wclk_i,
  input  logic                aclk_i,
  input  logic                ain_i,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                done_o,
  output logic                done_left_o
);
  localparam int CNT_W = $clog2(MAX_SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_SLOTS);
  localparam logic [CNT_W-1:0] WIN_LEN = CNT_W'(SAMPLE_W);

  logic                wclk_q, aclk_q, armed_q;
  logic [CNT_W-1:0]    cnt_q, cnt_eff, cnt_next, skip;
  logic [SAMPLE_W-1:0] sr_q, sr_base, sr_next;
  logic                wclk_edge, aclk_rise, is_i2s, is_rj, msb_first;
  logic                in_win, take, left_lvl;

  assign wclk_edge = primed_i & (wclk_i ^ wclk_q);
  assign aclk_rise = primed_i & aclk_i & ~aclk_q;
  assign is_i2s    = (fmt_i == FMT_I2S);
  assign is_rj     = (fmt_i == FMT_RJ);
  assign msb_first = is_i2s | ~lsb_first_i;
  assign left_lvl  = ~is_i2s;
  assign skip      = {{(CNT_W-1){1'b0}}, is_i2s};

  // a word-clock edge opens a new half: slot count and shift register restart
  assign cnt_eff = wclk_edge ? '0 : cnt_q;
  assign sr_base = wclk_edge ? '0 : sr_q;
  assign in_win  = is_rj | ((cnt_eff >= skip) && (cnt_eff < skip + WIN_LEN));
  assign take    = aclk_rise & in_win;

  always_comb begin
    sr_next = sr_base;
    if (take) begin
      if (msb_first) sr_next = {sr_base[SAMPLE_W-2:0], ain_i};
      else           sr_next = {ain_i, sr_base[SAMPLE_W-1:1]};
    end
    cnt_next = cnt_eff;
    if (aclk_rise && cnt_eff != CNT_MAX) cnt_next = cnt_eff + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q      <= 1'b0;
      aclk_q      <= 1'b0;
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      sr_q        <= '0;
      word_o      <= '0;
      done_o      <= 1'b0;
      done_left_o <= 1'b0;
    end else begin
      wclk_q  <= wclk_i;
      aclk_q  <= aclk_i;
      cnt_q   <= cnt_next;
      sr_q    <= sr_next;
      armed_q <= armed_q | wclk_edge;
      done_o  <= wclk_edge & armed_q;
      if (wclk_edge) begin
        word_o      <= sr_q;
        done_left_o <= (wclk_q == left_lvl);
      end
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R10
  AST_EDGE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wclk_edge |=> (cnt_q <= CNT_W'(1))); // R3
endmodule

// File: rtl/sarx_pair.sv
`timescale 1ns/1ps
module sarx_pair #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                done_i,
  input  logic                done_left_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] left_hold_q;
  logic                have_left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i && done_left_i) begin
        left_hold_q <= word_i;
        have_left_q <= 1'b1;
      end else if (done_i && have_left_q) begin
        left_o      <= left_hold_q;
        right_o     <= word_i;
        valid_o     <= 1'b1;
        have_left_q <= 1'b0;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7
  AST_VALID_NEEDS_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(have_left_q)); // R8
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx import sarx_pkg::*; #(
  parameter int SAMPLE_W    = 24,
  parameter int MAX_SLOTS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_i,
  input  logic                lsb_first_i,
  input  logic                wclk_i,
  input  logic                aclk_i,
  input  logic                ain_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int LINES = 3;

  logic [LINES-1:0]    line_s;
  logic                primed;
  logic [SAMPLE_W-1:0] word;
  logic                done, done_left;
  sarx_fmt_e           fmt;

  assign fmt = sarx_fmt_e'(fmt_i);

  // all three lines share one delay so data stays aligned with the bit clock
  sarx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ain_i, aclk_i, wclk_i}),
    .sync_o  (line_s),
    .primed_o(primed)
  );

  sarx_shift #(.SAMPLE_W(SAMPLE_W), .MAX_SLOTS(MAX_SLOTS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt),
    .lsb_first_i(lsb_first_i),
    .primed_i   (primed),
    .wclk_i     (line_s[0]),
    .aclk_i     (line_s[1]),
    .ain_i      (line_s[2]),
    .word_o     (word),
    .done_o     (done),
    .done_left_o(done_left)
  );

  sarx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word),
    .done_i     (done),
    .done_left_i(done_left),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o)
  );

  AST_FMT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_i != 2'd3); // R1
endmodule

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
  localparam int ACLK_H = 32;

  typedef struct packed {
    logic [1:0]  fmt;
    logic        lsb;
    logic [7:0]  slots;
    logic [23:0] l0, r0, l1, r1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 8'd24, 24'h123456, 24'hABCDEF, 24'h800001, 24'h7FFFFE},
    '{2'd0, 1'b1, 8'd32, 24'hC0FFEE, 24'h0F0F0F, 24'h000001, 24'h800000},
    '{2'd0, 1'b0, 8'd32, 24'h13579B, 24'hFEDCBA, 24'hA5A5A5, 24'h5A5A5A},
    '{2'd1, 1'b0, 8'd24, 24'h2468AC, 24'h987654, 24'hFFFFFF, 24'h000000},
    '{2'd1, 1'b0, 8'd40, 24'h400002, 24'hDEAD01, 24'h31415F, 24'h271828},
    '{2'd1, 1'b1, 8'd32, 24'h00FF00, 24'hF00F0F, 24'h800001, 24'h654321},
    '{2'd2, 1'b0, 8'd32, 24'hB16B00, 24'h0B1ABE, 24'h111111, 24'hEEEEEE},
    '{2'd2, 1'b1, 8'd25, 24'h8000FF, 24'h7F0001, 24'hC3C3C3, 24'h3C3C3C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        lsb = 1'b0;
  logic        wclk = 1'b0, aclk = 1'b0, ain = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int errors = 0, checks = 0;
  int cap_n = 0, long_pulse = 0;
  logic        prev_valid = 1'b0;
  logic [23:0] cap_l [4];
  logic [23:0] cap_r [4];

  always #4 clk = ~clk;

  serial_audio_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .lsb_first_i(lsb),
    .wclk_i(wclk), .aclk_i(aclk), .ain_i(ain),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      cap_n = 0;
      prev_valid = 1'b0;
    end else begin
      if (valid_o) begin
        if (cap_n < 4) begin
          cap_l[cap_n] = left_o;
          cap_r[cap_n] = right_o;
        end
        cap_n++;
        if (prev_valid) long_pulse++;
      end
      prev_valid = valid_o;
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic bit_at(logic [1:0] f, logic l, int slots, logic [23:0] w, int s);
    int k;
    case (f)
      2'd0: begin
        if (s >= 24) return 1'b1;
        k = s;
      end
      2'd1: begin
        if (s < slots - 24) return 1'b1;
        k = s - (slots - 24);
      end
      default: begin
        if (s < 1 || s > 24) return 1'b1;
        return w[24 - s];
      end
    endcase
    return l ? w[k] : w[23 - k];
  endfunction

  task automatic send_half(input logic lvl, input logic [23:0] w, input int slots);
    wclk = lvl;
    for (int s = 0; s < slots; s++) begin
      ain = bit_at(fmt, lsb, slots, w, s);
      #(ACLK_H) aclk = 1'b1;
      #(ACLK_H) aclk = 1'b0;
    end
  endtask

  task automatic do_reset(input logic [1:0] f, input logic l, input logic lvl);
    @(negedge clk);
    rst_n = 1'b0;
    fmt = f; lsb = l; wclk = lvl; aclk = 1'b0; ain = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic string tag_of(vec_t v);
    string t;
    case (v.fmt)
      2'd0:    t = "R3";
      2'd1:    t = "R4";
      default: t = "R5";
    endcase
    t = {"R2 R6 ", t};
    if (v.lsb && v.fmt != 2'd2) t = {t, " R9"};
    if (v.lsb && v.fmt == 2'd2) t = {t, " R1"};
    if (v.slots == 8'd24 || v.slots == 8'd25) t = {t, " R10"};
    return t;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 reset valid_o", {23'd0, valid_o}, 24'd0);
    chk("R8 reset left_o", left_o, 24'd0);
    chk("R8 reset right_o", right_o, 24'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t  v;
      logic  rl;
      string t;
      v  = VECS[i];
      rl = (v.fmt == 2'd2);
      t  = tag_of(v);
      do_reset(v.fmt, v.lsb, rl);
      send_half(rl, 24'h5A5A5A, int'(v.slots));
      send_half(~rl, v.l0, int'(v.slots));
      send_half(rl, v.r0, int'(v.slots));
      send_half(~rl, v.l1, int'(v.slots));
      send_half(rl, v.r1, int'(v.slots));
      send_half(~rl, 24'h000000, 4);
      repeat (20) @(negedge clk);
      chk($sformatf("R7 R8 vec %0d strobe count", i), 24'(cap_n), 24'd2);
      chk($sformatf("%s vec %0d left0", t, i), cap_l[0], v.l0);
      chk($sformatf("%s vec %0d right0", t, i), cap_r[0], v.r0);
      chk($sformatf("%s vec %0d left1", t, i), cap_l[1], v.l1);
      chk($sformatf("%s vec %0d right1", t, i), cap_r[1], v.r1);
      chk($sformatf("R7 vec %0d held left_o", i), left_o, v.l1);
    end

    // R8: start inside a left half; the partial left and the lone right give no strobe
    do_reset(2'd0, 1'b0, 1'b1);
    send_half(1'b1, 24'h111111, 24);
    send_half(1'b0, 24'h222222, 24);
    send_half(1'b1, 24'h3456AB, 24);
    send_half(1'b0, 24'hCDEF01, 24);
    send_half(1'b1, 24'h000000, 4);
    repeat (20) @(negedge clk);
    chk("R8 partial start strobe count", 24'(cap_n), 24'd1);
    chk("R8 partial start left", cap_l[0], 24'h3456AB);
    chk("R8 partial start right", cap_r[0], 24'hCDEF01);

    chk("R7 strobe width", 24'(long_pulse), 24'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule